// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a simple serial port. A word-addressed bus reads and writes a set of control, status and timing registers. A byte path leaves through a transmit output with a one-cycle valid strobe. A byte path enters through a receive input that fills a single holding slot. There is no queue: the slot holds one character. The `rx_ready` output tells the sender whether the slot is free. A line break reported on `rx_break` lands in the slot as a character carrying a break marker instead of data.

Software drains the slot by reading the receive-data word. It clears selected sticky status bits by writing ones to them. Writing a control word with its reset bit low returns all status state to its power-on values. One registered interrupt line is formed from status bits masked by enable bits. The timing and FIFO control words only store and return what software writes; no baud generation or shifting happens here.

Top module: `serial_regfront`

## Requirements
- R1: After reset, these words read back as follows: status-A (0x25) = 0x6040, status-B (0x26) = 0x4028, line-state (0x2D) = 0x0060, receive data (0x00) = 0x4000, control-A (0x20) = 0x0001, control-B (0x21) = 0x0001. After reset `rx_ready` = 1 and `irq` = 0.
- R2: The storage words at 0x20, 0x21, 0x22, 0x24, 0x2A, 0x2B and 0x2C keep the low 16 bits of a write and read them back.
- R3: Words 0x23 and 0x29, and any unmapped address, read 0 and ignore writes. Writes to the line-state word 0x2D are ignored.
- R4: A character offered on `rx_valid` while `rx_ready` = 1 is taken into the slot. The slot then reads 0x8000 | byte (bit 15 = valid). Status-A bit 9 is set, status-B bit 0 is set, line-state bit 5 is cleared and `rx_ready` drops.
- R5: A character or break offered while the slot is full is dropped, and the held value is unchanged.
- R6: Reading 0x00 while the slot is full returns the held value. The same read empties the slot: status-A bit 9 and status-B bit 0 clear, line-state bit 5 sets, and `rx_ready` rises. Reading 0x00 while the slot is empty returns the last held value and changes no state.
- R7: An accepted break stores 0x8800 (valid bit 15 and break bit 11, data 0). A break and a character offered in the same cycle store the break.
- R8: A write to 0x10 while control-B bit 2 is set emits the low byte on `tx_data` with `tx_valid` high for the following cycle. During that cycle status-A bit 13 reads 0; it reads 1 again one cycle later. With control-B bit 2 clear, the write emits nothing.
- R9: Writing ones clears only status-A bits {15,12,11,10,8,7,5,4} and status-B bits {15,13,12,11,10,8,7,6,4,2,1}. Bits 13, 14, 9 and 6 of status-A, and bits 14, 5, 3 and 0 of status-B, are unaffected.
- R10: `irq` is registered. It follows, one cycle late, (status-A bit 13 AND control-A bit 13) OR (status-A bit 9 AND control-A bit 9) OR (control-A bit 6 AND status-B bit 14).
- R11: A write to 0x21 with bit 0 = 0 stores the written value and returns status-A, status-B, line-state and the slot to their R1 values. The other storage words keep their contents, and a character offered in that same cycle is discarded.
- R12: A character accepted in the same cycle as a write of all ones to status-B still leaves status-B bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| tx_data | output | CHAR_W | Transmitted byte |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| rx_data | input | CHAR_W | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_break | input | 1 | Line break offered |
| rx_ready | output | 1 | Holding slot is free |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can act in the same clock edge. In the first, a write-one-to-clear of status-B coincides with a character arriving. The bench drives both in one cycle, and afterwards the data-ready bit must read set. In the second, a software reset coincides with a character arriving. The bench again drives both in one cycle, and the reset must win: the slot is empty, `rx_ready` is high and the receive word reads 0x4000. A break offered alongside a character is judged the same way, by the stored value 0x8800.

// File: rtl/serial_regfront_pkg.sv
package serial_regfront_pkg;

   localparam int unsigned A_RXD   = 'h00;
   localparam int unsigned A_TXD   = 'h10;
   localparam int unsigned A_S1    = 'h25;
   localparam int unsigned A_S2    = 'h26;
   localparam int unsigned A_LINE  = 'h2D;

   localparam int NUM_STORE = 7;
   localparam int IDX_CTRL1 = 0;
   localparam int IDX_CTRL2 = 1;

   localparam logic [15:0] S1_RST   = 16'h6040;
   localparam logic [15:0] S2_RST   = 16'h4028;
   localparam logic [15:0] LINE_RST = 16'h0060;
   localparam logic [15:0] HOLD_RST = 16'h4000;
   localparam logic [15:0] S1_W1C   = 16'h9DB0;
   localparam logic [15:0] S2_W1C   = 16'hBDD6;
   localparam logic [15:0] IRQ_SRC  = 16'h2200;

   localparam int B_TRDY    = 13;
   localparam int B_RRDY    = 9;
   localparam int B_RDR     = 0;
   localparam int B_RXEMPTY = 5;
   localparam int B_TXFE    = 14;
   localparam int B_VALID   = 15;
   localparam int B_BRK     = 11;
   localparam int B_TXEN    = 2;
   localparam int B_SRST    = 0;
   localparam int B_TXIE    = 6;

   function automatic int unsigned store_addr(input int idx);
      case (idx)
         0:       return 'h20;
         1:       return 'h21;
         2:       return 'h22;
         3:       return 'h24;
         4:       return 'h2A;
         5:       return 'h2B;
         default: return 'h2C;
      endcase
   endfunction

   function automatic logic [15:0] store_rst(input int idx);
      return (idx == IDX_CTRL1 || idx == IDX_CTRL2) ? 16'h0001 : 16'h0000;
   endfunction

endpackage

// File: rtl/serial_regfront_store.sv
module serial_regfront_store
   import serial_regfront_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int REG_W  = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [REG_W-1:0]                    wdata,
   output logic [NUM_STORE-1:0][REG_W-1:0]     regs_o,
   output logic                                rd_hit,
   output logic [REG_W-1:0]                    rd_val
);

   logic [REG_W-1:0] regs_q [NUM_STORE];

   for (genvar g = 0; g < NUM_STORE; g++) begin : g_word
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(store_addr(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[g] <= REG_W'(store_rst(g));
         else if (wr_en && addr == WADDR)
            regs_q[g] <= wdata;
      end
      assign regs_o[g] = regs_q[g];
   end

   always_comb begin
      rd_hit = 1'b0;
      rd_val = '0;
      for (int i = 0; i < NUM_STORE; i++) begin
         if (addr == ADDR_W'(store_addr(i))) begin
            rd_hit = 1'b1;
            rd_val = regs_q[i];
         end
      end
   end

endmodule

// File: rtl/serial_regfront_rxhold.sv
module serial_regfront_rxhold
   import serial_regfront_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              rx_valid,
   input  logic              rx_break,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              take,
   output logic              full_o,
   output logic [REG_W-1:0]  hold_o
);

   logic             full_q;
   logic [REG_W-1:0] hold_q;
   logic             accept;

   assign accept = !full_q && (rx_valid || rx_break);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= REG_W'(HOLD_RST);
      end else if (soft_rst) begin
         full_q <= 1'b0;
         hold_q <= REG_W'(HOLD_RST);
      end else if (accept) begin
         full_q <= 1'b1;
         if (rx_break)
            hold_q <= REG_W'((1 << B_VALID) | (1 << B_BRK));
         else
            hold_q <= REG_W'(1 << B_VALID) | REG_W'(rx_data);
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   assign full_o = full_q;
   assign hold_o = hold_q;

   // R5: an offer into a full slot leaves the held word alone
   a_r5_keep_held: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_valid || rx_break) && full_q && !soft_rst) |=> (hold_q == $past(hold_q)));

   // R6: draining the slot frees it
   a_r6_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (take && full_q) |=> !full_q);

endmodule

// File: rtl/serial_regfront_status.sv
module serial_regfront_status
   import serial_regfront_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr_s1,
   input  logic             wr_s2,
   input  logic [REG_W-1:0] wdata,
   input  logic             tx_fire,
   input  logic             slot_full,
   output logic [REG_W-1:0] s1_o,
   output logic [REG_W-1:0] s2_o,
   output logic [REG_W-1:0] line_o
);

   logic [REG_W-1:0] s1_q, s2_q, s1_d, s2_d;

   always_comb begin
      s1_d = s1_q & ~(wr_s1 ? (wdata & REG_W'(S1_W1C)) : '0);
      s1_d[B_TRDY] = !tx_fire;
      s2_d = s2_q & ~(wr_s2 ? (wdata & REG_W'(S2_W1C)) : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= REG_W'(S1_RST);
         s2_q <= REG_W'(S2_RST);
      end else if (soft_rst) begin
         s1_q <= REG_W'(S1_RST);
         s2_q <= REG_W'(S2_RST);
      end else begin
         s1_q <= s1_d;
         s2_q <= s2_d;
      end
   end

   always_comb begin
      s1_o = s1_q;
      s1_o[B_RRDY] = slot_full;
      s2_o = s2_q;
      s2_o[B_RDR] = slot_full;
      line_o = REG_W'(LINE_RST);
      line_o[B_RXEMPTY] = !slot_full;
   end

   // R9: a status write never disturbs the fixed status-B bits
   a_r9_s2_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_s2 && !soft_rst) |=> (s2_q[B_TXFE] == $past(s2_q[B_TXFE])));

endmodule

// File: rtl/serial_regfront_irq.sv
module serial_regfront_irq
   import serial_regfront_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] ctrl1,
   input  logic [REG_W-1:0] s1,
   input  logic             txfe,
   output logic             irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= (|(s1 & ctrl1 & REG_W'(IRQ_SRC))) || (ctrl1[B_TXIE] && txfe);
   end

   assign irq_o = irq_q;

   // R10: no request without some enable bit set the cycle before
   a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl1[B_TRDY] || ctrl1[B_RRDY] || ctrl1[B_TXIE]) |-> !irq_q);

endmodule

// File: rtl/serial_regfront.sv
module serial_regfront
   import serial_regfront_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int REG_W  = 16,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CHAR_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_valid,
   input  logic              rx_break,
   output logic              rx_ready,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] AD_RXD  = ADDR_W'(A_RXD);
   localparam logic [ADDR_W-1:0] AD_TXD  = ADDR_W'(A_TXD);
   localparam logic [ADDR_W-1:0] AD_S1   = ADDR_W'(A_S1);
   localparam logic [ADDR_W-1:0] AD_S2   = ADDR_W'(A_S2);
   localparam logic [ADDR_W-1:0] AD_LINE = ADDR_W'(A_LINE);
   localparam logic [ADDR_W-1:0] AD_CTL2 = ADDR_W'(store_addr(IDX_CTRL2));

   if (REG_W < 16) begin : g_bad_regw
      $error("REG_W must be at least 16");
   end
   if (DATA_W < REG_W) begin : g_bad_dataw
      $error("DATA_W must not be narrower than REG_W");
   end
   if (CHAR_W > B_BRK) begin : g_bad_charw
      $error("CHAR_W must stay below the break bit");
   end
   if (ADDR_W < 6) begin : g_bad_addrw
      $error("ADDR_W must reach address 0x2D");
   end

   logic [REG_W-1:0] wlo;
   assign wlo = bus_wdata[REG_W-1:0];
   if (DATA_W > REG_W) begin : g_upper
      logic unused_upper;
      assign unused_upper = ^bus_wdata[DATA_W-1:REG_W];
   end

   logic wr, rd, soft_rst, take, tx_fire, full;
   logic [NUM_STORE-1:0][REG_W-1:0] regs;
   logic [REG_W-1:0] ctrl1, ctrl2, s1, s2, line, hold, bank_val;
   logic bank_hit;
   logic              tx_valid_q;
   logic [CHAR_W-1:0] tx_data_q;

   assign wr       = bus_valid && bus_we;
   assign rd       = bus_valid && !bus_we;
   assign ctrl1    = regs[IDX_CTRL1];
   assign ctrl2    = regs[IDX_CTRL2];
   assign soft_rst = wr && bus_addr == AD_CTL2 && !wlo[B_SRST];
   assign take     = rd && bus_addr == AD_RXD && full;
   assign tx_fire  = wr && bus_addr == AD_TXD && ctrl2[B_TXEN];

   serial_regfront_store #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr), .addr(bus_addr), .wdata(wlo),
      .regs_o(regs), .rd_hit(bank_hit), .rd_val(bank_val)
   );

   serial_regfront_rxhold #(.CHAR_W(CHAR_W), .REG_W(REG_W)) u_rxhold (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_valid(rx_valid),
      .rx_break(rx_break), .rx_data(rx_data), .take(take),
      .full_o(full), .hold_o(hold)
   );

   serial_regfront_status #(.REG_W(REG_W)) u_status (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_s1(wr && bus_addr == AD_S1), .wr_s2(wr && bus_addr == AD_S2),
      .wdata(wlo), .tx_fire(tx_fire), .slot_full(full),
      .s1_o(s1), .s2_o(s2), .line_o(line)
   );

   serial_regfront_irq #(.REG_W(REG_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .ctrl1(ctrl1), .s1(s1),
      .txfe(s2[B_TXFE]), .irq_o(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
      end else begin
         tx_valid_q <= tx_fire;
         if (tx_fire)
            tx_data_q <= wlo[CHAR_W-1:0];
      end
   end

   assign tx_valid = tx_valid_q;
   assign tx_data  = tx_data_q;
   assign rx_ready = !full;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AD_RXD)       bus_rdata = DATA_W'(hold);
      else if (bus_addr == AD_S1)   bus_rdata = DATA_W'(s1);
      else if (bus_addr == AD_S2)   bus_rdata = DATA_W'(s2);
      else if (bus_addr == AD_LINE) bus_rdata = DATA_W'(line);
      else if (bank_hit)            bus_rdata = DATA_W'(bank_val);
   end

   // R8: a strobe only follows a write made while the transmitter was on
   a_r8_tx_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(ctrl2[B_TXEN]));

   // R8: transmit-ready is low while the strobe is out
   a_r8_trdy_low: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !s1[B_TRDY]);

   // R11: software reset leaves the slot free
   a_r11_reset_frees: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> rx_ready);

endmodule

// File: tb/serial_regfront_tb.sv
module serial_regfront_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_data, rx_data = '0;
   logic        tx_valid, rx_valid = 1'b0, rx_break = 1'b0, rx_ready, irq;

   int checks = 0, errors = 0;
   logic [15:0] mdl [7];

   always #2 clk = ~clk;

   serial_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq)
   );

   function automatic logic [5:0] st_addr(input int i);
      case (i)
         0: return 6'h20; 1: return 6'h21; 2: return 6'h22; 3: return 6'h24;
         4: return 6'h2A; 5: return 6'h2B; default: return 6'h2C;
      endcase
   endfunction

   function automatic logic exp_irq(input logic [15:0] c1, input logic [15:0] s1,
                                    input logic [15:0] s2);
      return (s1[13] & c1[13]) | (s1[9] & c1[9]) | (c1[6] & s2[14]);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bread(input logic [5:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bread(a, d);
      chk(req, d, exp);
   endtask

   task automatic send(input logic [7:0] b, input logic brk, input logic val);
      rx_data = b; rx_break = brk; rx_valid = val;
      @(negedge clk);
      rx_valid = 1'b0; rx_break = 1'b0;
   endtask

   task automatic write_with_rx(input logic [5:0] a, input logic [31:0] d, input logic [7:0] b);
      rx_data = b; rx_valid = 1'b1;
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 status-A", 6'h25, 32'h6040);
      rd_chk("R1 status-B", 6'h26, 32'h4028);
      rd_chk("R1 line-state", 6'h2D, 32'h0060);
      rd_chk("R1 receive word", 6'h00, 32'h4000);
      rd_chk("R1 control-A", 6'h20, 32'h0001);
      rd_chk("R1 control-B", 6'h21, 32'h0001);
      chk("R1 rx_ready", rx_ready, 1);
      chk("R1 irq", irq, 0);

      // R2 storage words keep the low half
      for (int i = 0; i < 7; i++) begin
         mdl[i] = (i < 2) ? 16'h0001 : 16'h0000;
         if (i >= 2) begin
            bwrite(st_addr(i), 32'hABCD_0000 | (32'h1111 * i));
            mdl[i] = 16'h1111 * i;
         end
      end
      for (int i = 2; i < 7; i++) rd_chk("R2 readback", st_addr(i), {16'h0, mdl[i]});

      // R3 unimplemented and read-only words
      bwrite(6'h23, 32'hFFFF_FFFF);
      bwrite(6'h29, 32'hFFFF_FFFF);
      bwrite(6'h2D, 32'h0000_0000);
      bwrite(6'h3F, 32'hFFFF_FFFF);
      rd_chk("R3 word 0x23", 6'h23, 0);
      rd_chk("R3 word 0x29", 6'h29, 0);
      rd_chk("R3 unmapped", 6'h3F, 0);
      rd_chk("R3 line-state write ignored", 6'h2D, 32'h0060);

      // R4 accept a character
      send(8'h5A, 0, 1);
      chk("R4 rx_ready low", rx_ready, 0);
      rd_chk("R4 status-A", 6'h25, 32'h6240);
      rd_chk("R4 status-B", 6'h26, 32'h4029);
      rd_chk("R4 line-state", 6'h2D, 32'h0040);

      // R9 write-one-to-clear leaves live bits
      bwrite(6'h25, 32'hFFFF_FFFF);
      bwrite(6'h26, 32'hFFFF_FFFF);
      rd_chk("R9 status-A", 6'h25, 32'h6240);
      rd_chk("R9 status-B", 6'h26, 32'h4029);

      // R5 drop while full, R6 drain
      send(8'h11, 0, 1);
      send(8'h00, 1, 0);
      rd_chk("R5 R6 held value", 6'h00, 32'h805A);
      chk("R6 rx_ready", rx_ready, 1);
      rd_chk("R6 status-A", 6'h25, 32'h6040);
      rd_chk("R6 status-B", 6'h26, 32'h4028);
      rd_chk("R6 line-state", 6'h2D, 32'h0060);
      rd_chk("R6 empty read", 6'h00, 32'h805A);
      chk("R6 empty read no effect", rx_ready, 1);

      // R7 break, and break beating a character
      send(8'h00, 1, 0);
      rd_chk("R7 break word", 6'h00, 32'h8800);
      send(8'h33, 1, 1);
      rd_chk("R7 break priority", 6'h00, 32'h8800);

      // R8 transmit
      bwrite(6'h10, 32'h0000_01A5);
      chk("R8 no strobe when off", tx_valid, 0);
      bwrite(6'h21, 32'h0000_0005);
      bwrite(6'h10, 32'hFFFF_FFC3);
      chk("R8 strobe", tx_valid, 1);
      chk("R8 byte", tx_data, 8'hC3);
      rd_chk("R8 trdy low", 6'h25, 32'h4040);
      chk("R8 strobe ends", tx_valid, 0);
      rd_chk("R8 trdy back", 6'h25, 32'h6040);

      // R10 interrupt timing and sources
      bwrite(6'h20, 32'h0000_2001);
      chk("R10 irq not yet", irq, 0);
      @(negedge clk);
      chk("R10 irq trdy", irq, exp_irq(16'h2001, 16'h6040, 16'h4028));
      bwrite(6'h20, 32'h0000_0201);
      @(negedge clk);
      chk("R10 irq rrdy idle", irq, 0);
      send(8'h77, 0, 1);
      chk("R10 irq rrdy lag", irq, 0);
      @(negedge clk);
      chk("R10 irq rrdy", irq, 1);
      bwrite(6'h20, 32'h0000_0041);
      @(negedge clk);
      chk("R10 irq tx empty", irq, 1);
      bwrite(6'h20, 32'h0000_0001);
      @(negedge clk);
      chk("R10 irq off", irq, 0);

      // R11 software reset with a character arriving the same cycle
      write_with_rx(6'h21, 32'h0000_0004, 8'h99);
      chk("R11 rx_ready", rx_ready, 1);
      rd_chk("R11 receive word", 6'h00, 32'h4000);
      rd_chk("R11 status-A", 6'h25, 32'h6040);
      rd_chk("R11 control-B kept", 6'h21, 32'h0004);
      rd_chk("R11 other word kept", 6'h2C, {16'h0, mdl[6]});
      bwrite(6'h21, 32'h0000_0001);

      // R12 clear-write and arrival in one cycle
      write_with_rx(6'h26, 32'hFFFF_FFFF, 8'h42);
      rd_chk("R12 status-B", 6'h26, 32'h4029);
      rd_chk("R12 data", 6'h00, 32'h8042);

      // random mix: R2 storage and R4/R6 receive path
      mdl[0] = 16'h0001; mdl[1] = 16'h0001;
      for (int n = 0; n < 300; n++) begin
         int op = $urandom % 3;
         int i  = $urandom % 7;
         if (op == 0) begin
            logic [31:0] v = $urandom;
            if (i == 1) v[0] = 1'b1;
            if (i == 1) v[2] = 1'b0;
            bwrite(st_addr(i), v);
            mdl[i] = v[15:0];
         end else if (op == 1) begin
            rd_chk("R2 random readback", st_addr(i), {16'h0, mdl[i]});
         end else begin
            logic [7:0] b = 8'($urandom);
            send(b, 0, 1);
            chk("R4 random ready", rx_ready, 0);
            rd_chk("R4 R6 random data", 6'h00, {16'h0, 8'h80, b});
            chk("R6 random freed", rx_ready, 1);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule